// File: doc/BRIEF.md
# SDRAM Single-Access Command Sequencer

This block turns one host request into the full SDRAM command sequence for a single-word access under a closed-page policy. It opens the row with an activate, issues the read or write with auto-precharge after the row-to-column delay, and then holds off the next request until the bank is idle again. The host side is a valid/ready handshake. The request carries direction, bank, row, column, 64-bit write data and an 8-bit byte mask.

Reads and writes use the byte mask at different times. A write mask goes out with the write data in the same cycle. A read mask goes out two cycles before the read data returns, so it follows the selected CAS latency. Returned data is captured CAS-latency cycles after the read command and handed to the host with a one-cycle valid strobe. A `done` pulse marks the cycle in which the sequencer can take the next request, and that request's activate then lands exactly when the bank may be reopened. Refresh and power-up initialisation are handled elsewhere. This block assumes it owns the command bus.

Top module: `sdram_access_seq`

## Requirements
- R1: While reset is asserted and after it is released with no request, the command bus carries NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1), `req_ready` is 1, `done`, `rd_valid` and `sd_dq_oe` are 0, and `sd_dqm` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. In the next cycle the bus carries ACTIVATE (0,0,1,1), with the bank on `sd_ba` and the row on `sd_addr`.
- R3: Exactly 2 cycles after the activate, the bus carries READ (0,1,0,1) or WRITE (0,1,0,0), with the same bank, the column on `sd_addr[8:0]`, `sd_addr[10]` = 1 (auto-precharge) and all other address bits 0.
- R4: On a write, `sd_dq_out` equals the request data, `sd_dq_oe` is 1 and `sd_dqm` equals the request mask, all in the cycle of the write command. `sd_dq_oe` is 0 in every other cycle.
- R5: On a read, `sd_dqm` equals the request mask (bit i = 1 blanks byte i) for one cycle, CL-2 cycles after the read command. `sd_dqm` is 0 in every cycle that is not a write command or such a read-mask slot.
- R6: Read data on `sd_dq_in` is sampled at the end of the cycle that lies CL cycles after the read command. In the next cycle `rd_data` shows it and `rd_valid` is 1 for exactly one cycle.
- R7: `cfg_cl3` is sampled when a request is taken (1 selects CL = 3, 0 selects CL = 2). Changing it afterwards does not affect that access.
- R8: `done` is 1 for exactly one cycle, 6 cycles after the activate, and `req_ready` is 1 in that cycle. A request taken then has its activate 7 cycles after the previous one, which meets the 70 ns row cycle and the write-to-activate recovery at 100 MHz.
- R9: From the activate cycle until the `done` cycle, `req_ready` is 0. A request held on the inputs in that time creates no command until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Bank address |
| req_row | input | 13 | Row address |
| req_col | input | 9 | Column address |
| req_wdata | input | 64 | Write data |
| req_mask | input | 8 | Byte mask, 1 = byte suppressed |
| cfg_cl3 | input | 1 | CAS latency select, 1 = 3, 0 = 2 |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select to memory |
| sd_addr | output | 13 | Multiplexed row/column address |
| sd_dqm | output | 8 | Byte mask to memory |
| sd_dq_out | output | 64 | Write data to memory |
| sd_dq_oe | output | 1 | Data bus output enable |
| sd_dq_in | input | 64 | Read data from memory |
| rd_valid | output | 1 | Read data strobe to host |
| rd_data | output | 64 | Captured read data |
| done | output | 1 | Access finished, bank reusable |

## Verification
The bench goes after the different mask timing of reads and writes. If the read mask is sent in the write's cycle, or with the wrong latency, the memory model returns the real bytes instead of blanked zeros, and the read word no longer matches. It switches `cfg_cl3` while a CL-3 read is still in flight. A design that uses the live input would sample the bus one cycle early and capture the model's filler pattern. Requests are chained back to back with the next request already on the inputs. An early `done` or a `req_ready` leak would show as a command in a cycle where none is expected, or as an activate closer than 7 cycles to the previous one. The address corners (bank 3, row 8191, column 511) expose a column that overlaps the auto-precharge bit or a truncated row.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_NOP = 4'b0111,
      CMD_ACT = 4'b0011,
      CMD_RD  = 4'b0101,
      CMD_WR  = 4'b0100
   } sd_cmd_e;

   function automatic int unsigned umax(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdseq_ctrl.sv
module sdseq_ctrl #(
   parameter int unsigned LAST_RD = 6,
   parameter int unsigned LAST_WR = 6,
   parameter int unsigned CNT_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             req_cl3,
   output logic             ready,
   output logic             accept,
   output logic             busy,
   output logic [CNT_W-1:0] cnt,
   output logic             is_write,
   output logic             cl3,
   output logic             done
);

   logic at_last;

   always_comb begin
      at_last = busy && (cnt == (is_write ? CNT_W'(LAST_WR) : CNT_W'(LAST_RD)));
      ready   = !busy || at_last;
      accept  = req_valid && ready;
      done    = at_last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt      <= '0;
         is_write <= 1'b0;
         cl3      <= 1'b0;
      end else if (accept) begin
         busy     <= 1'b1;
         cnt      <= '0;
         is_write <= req_write;
         cl3      <= req_cl3;
      end else if (at_last) begin
         busy <= 1'b0;
      end else if (busy) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/sdseq_cmd_drive.sv
module sdseq_cmd_drive
   import sdseq_pkg::*;
#(
   parameter int unsigned DQ_W       = 64,
   parameter int unsigned MASK_W     = 8,
   parameter int unsigned BA_W       = 2,
   parameter int unsigned ROW_W      = 13,
   parameter int unsigned COL_W      = 9,
   parameter int unsigned ADDR_W     = 13,
   parameter int unsigned AP_BIT     = 10,
   parameter int unsigned CNT_W      = 3,
   parameter int unsigned T_RCD      = 2,
   parameter int unsigned CL_LO      = 2,
   parameter int unsigned CL_HI      = 3,
   parameter int unsigned DQM_RD_LAT = 2
) (
   input  logic              busy,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              is_write,
   input  logic              cl3,
   input  logic [BA_W-1:0]   bank,
   input  logic [ROW_W-1:0]  row,
   input  logic [COL_W-1:0]  col,
   input  logic [DQ_W-1:0]   wdata,
   input  logic [MASK_W-1:0] mask,
   output sd_cmd_e           cmd,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic [MASK_W-1:0] dqm,
   output logic [DQ_W-1:0]   dq_out,
   output logic              dq_oe,
   output logic              rd_issue
);

   // read mask slot: DQM_RD_LAT cycles ahead of the data
   localparam int unsigned MSK_LO = T_RCD + CL_LO - DQM_RD_LAT;
   localparam int unsigned MSK_HI = T_RCD + CL_HI - DQM_RD_LAT;

   logic act_cyc, rw_cyc, wr_cyc, rmask_cyc;

   always_comb begin
      act_cyc   = busy && (cnt == '0);
      rw_cyc    = busy && (cnt == CNT_W'(T_RCD));
      wr_cyc    = rw_cyc && is_write;
      rd_issue  = rw_cyc && !is_write;
      rmask_cyc = busy && !is_write &&
                  (cnt == (cl3 ? CNT_W'(MSK_HI) : CNT_W'(MSK_LO)));

      cmd = CMD_NOP;
      if (act_cyc)     cmd = CMD_ACT;
      else if (wr_cyc) cmd = CMD_WR;
      else if (rw_cyc) cmd = CMD_RD;

      ba   = (act_cyc || rw_cyc) ? bank : '0;
      addr = '0;
      if (act_cyc) begin
         addr[ROW_W-1:0] = row;
      end else if (rw_cyc) begin
         addr[COL_W-1:0] = col;
         addr[AP_BIT]    = 1'b1;
      end

      dqm    = (wr_cyc || rmask_cyc) ? mask : '0;
      dq_oe  = wr_cyc;
      dq_out = wr_cyc ? wdata : '0;
   end

endmodule

// File: rtl/sdseq_rd_capture.sv
module sdseq_rd_capture #(
   parameter int unsigned DQ_W  = 64,
   parameter int unsigned CL_LO = 2,
   parameter int unsigned CL_HI = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_issue,
   input  logic            cl_hi_sel,
   input  logic [DQ_W-1:0] dq_in,
   output logic            rd_valid,
   output logic [DQ_W-1:0] rd_data
);

   localparam int unsigned LANES = DQ_W / 8;

   logic [CL_HI:1] tok;
   logic           sel_q;
   logic           hit;

   assign hit = sel_q ? tok[CL_HI] : tok[CL_LO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tok      <= '0;
         sel_q    <= 1'b0;
         rd_valid <= 1'b0;
      end else begin
         tok      <= {tok[CL_HI-1:1], rd_issue};
         if (rd_issue) sel_q <= cl_hi_sel;
         rd_valid <= hit;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   rd_data[g*8 +: 8] <= '0;
         else if (hit) rd_data[g*8 +: 8] <= dq_in[g*8 +: 8];
      end
   end

endmodule

// File: rtl/sdram_access_seq.sv
module sdram_access_seq
   import sdseq_pkg::*;
#(
   parameter int unsigned DQ_W       = 64,
   parameter int unsigned BA_W       = 2,
   parameter int unsigned ROW_W      = 13,
   parameter int unsigned COL_W      = 9,
   parameter int unsigned ADDR_W     = 13,
   parameter int unsigned AP_BIT     = 10,
   parameter int unsigned T_RCD      = 2,
   parameter int unsigned T_RAS      = 5,
   parameter int unsigned T_RC       = 7,
   parameter int unsigned T_RP       = 2,
   parameter int unsigned T_WR       = 1,
   parameter int unsigned T_DAL_MIN  = 5,
   parameter int unsigned CL_LO      = 2,
   parameter int unsigned CL_HI      = 3,
   parameter int unsigned DQM_RD_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [BA_W-1:0]   req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic [DQ_W-1:0]   req_wdata,
   input  logic [DQ_W/8-1:0] req_mask,
   input  logic              cfg_cl3,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BA_W-1:0]   sd_ba,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [DQ_W/8-1:0] sd_dqm,
   output logic [DQ_W-1:0]   sd_dq_out,
   output logic              sd_dq_oe,
   input  logic [DQ_W-1:0]   sd_dq_in,
   output logic              rd_valid,
   output logic [DQ_W-1:0]   rd_data,
   output logic              done
);

   localparam int unsigned MASK_W   = DQ_W / 8;
   localparam int unsigned RD_CLOSE = umax(T_RC, umax(T_RAS, T_RCD + 1) + T_RP);
   localparam int unsigned WR_CLOSE = umax(T_RC, umax(T_RAS + T_RP,
                                      T_RCD + umax(T_WR + T_RP, T_DAL_MIN)));
   localparam int unsigned LAST_RD  = umax(RD_CLOSE - 1, T_RCD + CL_HI + 1);
   localparam int unsigned LAST_WR  = WR_CLOSE - 1;
   localparam int unsigned CNT_W    = $clog2(umax(LAST_RD, LAST_WR) + 1);

   if (DQ_W % 8 != 0)            $error("data width must be whole bytes");
   if (ROW_W > ADDR_W)           $error("row does not fit the address bus");
   if (AP_BIT >= ADDR_W)         $error("auto-precharge bit outside the address bus");
   if (COL_W > AP_BIT)           $error("column overlaps the auto-precharge bit");
   if (CL_LO < DQM_RD_LAT)       $error("read mask would precede the read command");
   if (CL_HI < CL_LO || CL_HI < 2) $error("bad CAS latency pair");
   if (T_RCD < 1)                $error("row-to-column delay must be at least 1");

   logic              accept, busy, is_write, cl3;
   logic [CNT_W-1:0]  cnt;
   logic [BA_W-1:0]   bank_q;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   logic [DQ_W-1:0]   wdata_q;
   logic [MASK_W-1:0] mask_q;
   logic              rd_issue;
   sd_cmd_e           cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q  <= '0;
         row_q   <= '0;
         col_q   <= '0;
         wdata_q <= '0;
         mask_q  <= '0;
      end else if (accept) begin
         bank_q  <= req_bank;
         row_q   <= req_row;
         col_q   <= req_col;
         wdata_q <= req_wdata;
         mask_q  <= req_mask;
      end
   end

   sdseq_ctrl #(
      .LAST_RD (LAST_RD),
      .LAST_WR (LAST_WR),
      .CNT_W   (CNT_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_cl3   (cfg_cl3),
      .ready     (req_ready),
      .accept    (accept),
      .busy      (busy),
      .cnt       (cnt),
      .is_write  (is_write),
      .cl3       (cl3),
      .done      (done)
   );

   sdseq_cmd_drive #(
      .DQ_W       (DQ_W),
      .MASK_W     (MASK_W),
      .BA_W       (BA_W),
      .ROW_W      (ROW_W),
      .COL_W      (COL_W),
      .ADDR_W     (ADDR_W),
      .AP_BIT     (AP_BIT),
      .CNT_W      (CNT_W),
      .T_RCD      (T_RCD),
      .CL_LO      (CL_LO),
      .CL_HI      (CL_HI),
      .DQM_RD_LAT (DQM_RD_LAT)
   ) u_drive (
      .busy     (busy),
      .cnt      (cnt),
      .is_write (is_write),
      .cl3      (cl3),
      .bank     (bank_q),
      .row      (row_q),
      .col      (col_q),
      .wdata    (wdata_q),
      .mask     (mask_q),
      .cmd      (cmd),
      .ba       (sd_ba),
      .addr     (sd_addr),
      .dqm      (sd_dqm),
      .dq_out   (sd_dq_out),
      .dq_oe    (sd_dq_oe),
      .rd_issue (rd_issue)
   );

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

   sdseq_rd_capture #(
      .DQ_W  (DQ_W),
      .CL_LO (CL_LO),
      .CL_HI (CL_HI)
   ) u_rdcap (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_issue  (rd_issue),
      .cl_hi_sel (cl3),
      .dq_in     (sd_dq_in),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

endmodule

// File: rtl/sdseq_checker.sv
module sdseq_checker
   import sdseq_pkg::*;
#(
   parameter int unsigned T_RCD = 2,
   parameter int unsigned T_RC  = 7
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic [3:0] cmd,
   input logic       dq_oe,
   input logic       done,
   input logic       rd_valid
);

   localparam int unsigned SA_W = $clog2(T_RC + T_RCD + 4) + 1;

   logic [SA_W-1:0] since_act;
   logic            is_act, is_rw, is_wr;

   assign is_act = (cmd == CMD_ACT);
   assign is_wr  = (cmd == CMD_WR);
   assign is_rw  = (cmd == CMD_RD) || is_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    since_act <= '1;
      else if (is_act)               since_act <= SA_W'(1);
      else if (since_act != '1)      since_act <= since_act + 1'b1;
   end

   p_act_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |-> $past(req_valid && req_ready));

   p_rw_after_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
      is_rw |-> since_act == SA_W'(T_RCD));

   p_oe_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr |-> dq_oe);

   p_oe_only_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> is_wr);

   p_rdv_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   p_act_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |-> since_act >= SA_W'(T_RC));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

   p_no_cmd_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !req_valid) |=> (cmd == CMD_NOP));

endmodule

bind sdram_access_seq sdseq_checker #(
   .T_RCD (T_RCD),
   .T_RC  (T_RC)
) u_sdseq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .cmd       ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
   .dq_oe     (sd_dq_oe),
   .done      (done),
   .rd_valid  (rd_valid)
);

// File: tb/tb_sdram_access_seq.sv
module tb_sdram_access_seq;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_ready, req_write, cfg_cl3;
   logic [1:0]  req_bank;
   logic [12:0] req_row;
   logic [8:0]  req_col;
   logic [63:0] req_wdata;
   logic [7:0]  req_mask;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
   logic [1:0]  sd_ba;
   logic [12:0] sd_addr;
   logic [7:0]  sd_dqm;
   logic [63:0] sd_dq_out, sd_dq_in, rd_data;
   logic        rd_valid, done;

   always #10 clk = ~clk;   // 50 MHz

   sdram_access_seq dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
      .req_col(req_col), .req_wdata(req_wdata), .req_mask(req_mask),
      .cfg_cl3(cfg_cl3), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
      .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
      .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
      .sd_dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
   );

   localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100;
   localparam logic [63:0] FILLER = 64'hA5A5_5A5A_F00F_0FF0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit mon_on = 1'b0;

   // scoreboard: expectations keyed by cycle
   logic [3:0]  exp_cmd  [int];
   logic [1:0]  exp_ba   [int];
   logic [12:0] exp_addr [int];
   logic [7:0]  exp_dqm  [int];
   logic [63:0] exp_wdat [int];
   logic [63:0] exp_rdv  [int];
   bit          exp_done [int];
   bit          exp_busy [int];
   int          rd_cl_at [int];

   // shadow (bench) and device model memories
   logic [63:0] sh_mem  [logic [23:0]];
   logic [63:0] dev_mem [logic [23:0]];
   logic [23:0] pend    [int];
   logic [7:0]  dqm_hist[int];
   logic [12:0] open_row[4];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [63:0] init_word(logic [23:0] k);
      return {k, k ^ 24'h5A5A5A, k[15:0] ^ 16'hC3C3};
   endfunction

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
      end
   endtask

   // monitor + memory model, outputs sampled away from the active edge
   always @(negedge clk) begin
      if (mon_on) begin
         logic [3:0]  c;
         logic [23:0] k;
         logic [63:0] w;
         c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
         if (exp_cmd.exists(cyc)) begin
            check(c == exp_cmd[cyc], "R2/R3 command", 64'(c), 64'(exp_cmd[cyc]));
            check(sd_ba == exp_ba[cyc], "R2/R3 bank", 64'(sd_ba), 64'(exp_ba[cyc]));
            check(sd_addr == exp_addr[cyc], "R2/R3 address", 64'(sd_addr), 64'(exp_addr[cyc]));
            exp_cmd.delete(cyc);
         end else if (c != NOP) begin
            check(1'b0, "R9 unexpected command", 64'(c), 64'(NOP));
         end
         if (exp_dqm.exists(cyc) || sd_dqm != 8'h00) begin
            logic [7:0] e;
            e = exp_dqm.exists(cyc) ? exp_dqm[cyc] : 8'h00;
            check(sd_dqm == e, "R4/R5 dqm", 64'(sd_dqm), 64'(e));
         end
         if (exp_wdat.exists(cyc) || sd_dq_oe) begin
            check(sd_dq_oe == exp_wdat.exists(cyc), "R4 output enable",
                  64'(sd_dq_oe), 64'(exp_wdat.exists(cyc)));
            if (exp_wdat.exists(cyc))
               check(sd_dq_out == exp_wdat[cyc], "R4 write data", sd_dq_out, exp_wdat[cyc]);
         end
         if (exp_done.exists(cyc) || done) begin
            check(done == exp_done.exists(cyc), "R8 done", 64'(done), 64'(exp_done.exists(cyc)));
            if (exp_done.exists(cyc)) check(req_ready, "R8 ready at done", 64'(req_ready), 64'd1);
         end
         if (exp_busy.exists(cyc))
            check(!req_ready, "R9 ready low while busy", 64'(req_ready), 64'd0);
         if (exp_rdv.exists(cyc) || rd_valid) begin
            check(rd_valid == exp_rdv.exists(cyc), "R6 rd_valid",
                  64'(rd_valid), 64'(exp_rdv.exists(cyc)));
            if (exp_rdv.exists(cyc)) begin
               check(rd_data == exp_rdv[cyc], "R5/R6/R7 read data", rd_data, exp_rdv[cyc]);
               exp_rdv.delete(cyc);
            end
         end
         // device model
         dqm_hist[cyc] = sd_dqm;
         if (c == ACT) open_row[sd_ba] = sd_addr;
         if (c == WR || c == RD) begin
            k = {sd_ba, open_row[sd_ba], sd_addr[8:0]};
            check(sd_addr[10], "R3 auto-precharge bit", 64'(sd_addr[10]), 64'd1);
            if (c == WR) begin
               w = dev_mem.exists(k) ? dev_mem[k] : init_word(k);
               for (int i = 0; i < 8; i++)
                  if (!sd_dqm[i]) w[i*8 +: 8] = sd_dq_out[i*8 +: 8];
               dev_mem[k] = w;
            end else begin
               pend[cyc + (rd_cl_at.exists(cyc) ? rd_cl_at[cyc] : 2)] = k;
            end
         end
         if (pend.exists(cyc)) begin
            k = pend[cyc];
            w = dev_mem.exists(k) ? dev_mem[k] : init_word(k);
            for (int i = 0; i < 8; i++)
               if (dqm_hist.exists(cyc - 2) && dqm_hist[cyc - 2][i]) w[i*8 +: 8] = 8'h00;
            sd_dq_in = w;
            pend.delete(cyc);
         end else begin
            sd_dq_in = FILLER;
         end
      end
   end

   // driver: presents a request, waits for acceptance, pushes expectations
   task automatic do_req(bit wr, logic [1:0] b, logic [12:0] r, logic [8:0] col,
                         logic [63:0] d, logic [7:0] m, bit cl3);
      int a, cl;
      logic [23:0] k;
      logic [12:0] ca;
      logic [63:0] w;
      req_valid = 1'b1; req_write = wr; req_bank = b; req_row = r;
      req_col = col; req_wdata = d; req_mask = m; cfg_cl3 = cl3;
      while (!req_ready) @(negedge clk);
      a  = cyc;
      k  = {b, r, col};
      ca = 13'(col);
      ca[10] = 1'b1;
      exp_cmd[a+1] = ACT;          exp_ba[a+1] = b; exp_addr[a+1] = r;
      exp_cmd[a+3] = wr ? WR : RD; exp_ba[a+3] = b; exp_addr[a+3] = ca;
      for (int j = 1; j <= 6; j++) exp_busy[a+j] = 1'b1;
      exp_done[a+7] = 1'b1;
      w = sh_mem.exists(k) ? sh_mem[k] : init_word(k);
      if (wr) begin
         exp_wdat[a+3] = d;
         exp_dqm[a+3]  = m;
         for (int i = 0; i < 8; i++) if (!m[i]) w[i*8 +: 8] = d[i*8 +: 8];
         sh_mem[k] = w;
      end else begin
         cl = cl3 ? 3 : 2;                  // R7
         rd_cl_at[a+3] = cl;
         exp_dqm[a+1+cl] = m;               // R5: CL-2 after the read command
         for (int i = 0; i < 8; i++) if (m[i]) w[i*8 +: 8] = 8'h00;
         exp_rdv[a+4+cl] = w;               // R6
      end
      @(negedge clk);
      req_valid = 1'b0;
      cfg_cl3   = ~cl3;                     // R7: late change must not matter
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_bank = '0;
      req_row = '0; req_col = '0; req_wdata = '0; req_mask = '0; cfg_cl3 = 1'b0;
      sd_dq_in = FILLER;
      repeat (3) @(negedge clk);
      // R1: reset state
      check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == NOP, "R1 NOP in reset",
            64'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 64'(NOP));
      check(req_ready && !done && !rd_valid && !sd_dq_oe && sd_dqm == 0, "R1 idle outputs",
            64'({req_ready, done, rd_valid, sd_dq_oe, sd_dqm}), 64'h800);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
      mon_on = 1'b1;
      @(negedge clk);

      do_req(1, 2'd0, 13'd5, 9'd7, 64'h0123_4567_89AB_CDEF, 8'h00, 0);
      do_req(0, 2'd0, 13'd5, 9'd7, 64'h0, 8'h00, 0);
      do_req(1, 2'd1, 13'd100, 9'd33, 64'hFFEE_DDCC_BBAA_9988, 8'hF0, 1);
      do_req(0, 2'd1, 13'd100, 9'd33, 64'h0, 8'h00, 1);
      do_req(0, 2'd1, 13'd100, 9'd33, 64'h0, 8'h0F, 1);
      do_req(0, 2'd0, 13'd5, 9'd7, 64'h0, 8'h81, 0);
      do_req(1, 2'd3, 13'd8191, 9'd511, 64'hDEAD_BEEF_CAFE_F00D, 8'h00, 0);
      do_req(0, 2'd3, 13'd8191, 9'd511, 64'h0, 8'h00, 1);
      repeat (4) @(negedge clk);
      do_req(0, 2'd2, 13'd42, 9'd256, 64'h0, 8'h3C, 0);
      repeat (3) @(negedge clk);
      do_req(1, 2'd2, 13'd42, 9'd256, 64'h1111_2222_3333_4444, 8'h55, 1);
      do_req(0, 2'd2, 13'd42, 9'd256, 64'h0, 8'h00, 1);
      repeat (15) @(negedge clk);

      check(exp_rdv.size() == 0, "R6 all reads returned", 64'(exp_rdv.size()), 64'd0);
      check(exp_cmd.size() == 0, "R2/R3 all commands seen", 64'(exp_cmd.size()), 64'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      if (cyc > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule